// File: doc/BRIEF.md
# Keyboard Command Responder and Lock-Key Filter

This block sits on the keyboard side of a serial channel. Host command bytes from the transmit path come in on a strobe. The block answers a reset command and a layout query with two-byte replies. After a set-LED command it swallows the next host byte.

Scancode events come in on a second strobe. A strobe flagged as an extended prefix only arms the extended table. Any other event passes through a filter that suppresses alternating press and release events of the caps and num lock keys. Events that survive are translated through a small lookup memory, and the release bit is kept.

Replies and translated codes go into a small queue. The queue presents one byte per cycle to the downstream receive path.

Top module: `kbd_cmd_filter`

## Requirements
- R1: After reset the queue is empty and `out_valid` stays low until a byte is queued.
- R2: Command 0x01 queues 0xFF and then 0x04. The first byte appears on `out_byte` in the cycle after the strobe, and the second in the cycle after that.
- R3: Command 0x07 queues 0xFE and then 0x00.
- R4: Command 0x0E queues nothing. The next host byte, whatever its value, is discarded without any reply. The byte after that is decoded normally again.
- R5: A command byte other than 0x01, 0x07 or 0x0E queues nothing.
- R6: A key event with `key_ext` low queues `{key_code[7], T[key_code[6:0]]}`. In the normal table, T[i] = (i + NORM_BIAS) mod 128, with NORM_BIAS defaulting to 17.
- R7: A strobe with `key_ext` high queues nothing and arms the extended table. The next queued key uses E[i] = (i + EXT_BIAS) mod 128, with EXT_BIAS defaulting to 64. The arm is then cleared.
- R8: Caps lock (press 58, release 186) and num lock (press 69, release 197) each keep a 2-bit mode that starts at 0. A press flips bit 0 and is dropped when the mode becomes 2. A release flips bit 1 and is dropped when the mode becomes 3. A dropped event leaves the extended arm untouched.
- R9: When a command and a key arrive in the same cycle, the reply bytes are queued before the key byte. Bytes leave in the order they were queued, one per cycle.
- R10: The queue holds at most DEPTH bytes (8 by default). Bytes that do not fit in a cycle are dropped, the last-ordered ones first.
- R11: `out_valid` is high exactly while the queue holds a byte. Each byte is presented for one cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | Host command byte strobe |
| cmd_byte | input | 8 | Host command byte |
| key_valid | input | 1 | Scancode event strobe |
| key_code | input | 8 | Scancode; bit 7 marks release |
| key_ext | input | 1 | Marks the strobe as an extended prefix |
| out_valid | output | 1 | Queue output byte valid |
| out_byte | output | 8 | Byte toward the receive queue |

## Verification
On every cycle, the assertions check these behaviours:
- The queue occupancy never goes past its depth.
- A reset command on an idle queue produces 0xFF in the next cycle.
- A swallowed LED byte, an unknown command and an extended prefix each leave an idle queue empty.

Only the bench's scenarios can show the rest:
- the full reply sequences;
- the four-step lock-key drop pattern;
- table selection and how long the extended arm lasts;
- ordering of same-cycle bytes;
- which bytes are lost when the queue overflows.

// File: rtl/kbd_cmd_filter.sv
module kbd_cmd_filter #(
  parameter int         DEPTH     = 8,
  parameter logic [6:0] NORM_BIAS = 7'd17,
  parameter logic [6:0] EXT_BIAS  = 7'd64
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_valid,
  input  logic [7:0] cmd_byte,
  input  logic       key_valid,
  input  logic [7:0] key_code,
  input  logic       key_ext,
  output logic       out_valid,
  output logic [7:0] out_byte
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = AW + 1;
  localparam logic [7:0] CMD_RST = 8'h01, CMD_LAYOUT = 8'h07, CMD_LED = 8'h0E;
  localparam logic [7:0] CAPS_P = 8'd58, CAPS_R = 8'd186, NUM_P = 8'd69, NUM_R = 8'd197;

  logic [6:0] norm_tab [128];
  logic [6:0] ext_tab  [128];
  for (genvar i = 0; i < 128; i++) begin : g_tab
    assign norm_tab[i] = 7'(i) + NORM_BIAS;
    assign ext_tab[i]  = 7'(i) + EXT_BIAS;
  end

  logic          led_pend, ext_arm;
  logic [1:0]    caps_m, num_m;
  logic [7:0]    mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic [CW-1:0] count;

  logic       is_key, caps_p, caps_r, num_p, num_r, drop, key_push;
  logic [1:0] caps_nx, num_nx;
  logic [7:0] key_out;

  assign is_key  = key_valid && !key_ext;
  assign caps_p  = is_key && key_code == CAPS_P;
  assign caps_r  = is_key && key_code == CAPS_R;
  assign num_p   = is_key && key_code == NUM_P;
  assign num_r   = is_key && key_code == NUM_R;
  assign caps_nx = caps_m ^ {caps_r, caps_p};
  assign num_nx  = num_m ^ {num_r, num_p};
  assign drop    = (caps_p && caps_nx == 2'd2) || (caps_r && caps_nx == 2'd3) ||
                   (num_p && num_nx == 2'd2)   || (num_r && num_nx == 2'd3);
  assign key_push = is_key && !drop;
  assign key_out  = {key_code[7], ext_arm ? ext_tab[key_code[6:0]] : norm_tab[key_code[6:0]]};

  logic       cmd_live, rsp_pair;
  logic [7:0] rsp0, rsp1;
  assign cmd_live = cmd_valid && !led_pend;
  assign rsp_pair = cmd_live && (cmd_byte == CMD_RST || cmd_byte == CMD_LAYOUT);
  assign rsp0     = (cmd_byte == CMD_RST) ? 8'hFF : 8'hFE;
  assign rsp1     = (cmd_byte == CMD_RST) ? 8'h04 : 8'h00;

  logic [7:0]  slot [3];
  logic [CW:0] n_in, room, n_acc;
  logic        pop;

  assign slot[0] = rsp_pair ? rsp0 : key_out;
  assign slot[1] = rsp1;
  assign slot[2] = key_out;
  assign n_in    = (rsp_pair ? (CW+1)'(2) : '0) + (CW+1)'(key_push);
  assign pop     = count != '0;
  assign room    = (CW+1)'(DEPTH) - {1'b0, count} + (CW+1)'(pop);
  assign n_acc   = (n_in > room) ? room : n_in;

  assign out_valid = pop;
  assign out_byte  = mem[rptr];

  always_ff @(posedge clk) begin
    for (int k = 0; k < 3; k++)
      if ((CW+1)'(k) < n_acc) mem[wptr + AW'(k)] <= slot[k];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr <= '0; rptr <= '0; count <= '0;
      led_pend <= 1'b0; ext_arm <= 1'b0;
      caps_m <= 2'd0; num_m <= 2'd0;
    end else begin
      if (pop) rptr <= rptr + 1'b1;
      wptr  <= wptr + AW'(n_acc);
      count <= count - CW'(pop) + CW'(n_acc);
      if (cmd_valid) begin
        if (led_pend) led_pend <= 1'b0;
        else if (cmd_byte == CMD_LED) led_pend <= 1'b1;
      end
      caps_m <= caps_nx;
      num_m  <= num_nx;
      if (key_valid && key_ext) ext_arm <= 1'b1;
      else if (key_push) ext_arm <= 1'b0;
    end
  end

  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH)); // R10
  AST_RESET_REPLY: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !led_pend && cmd_byte == CMD_RST && count == '0)
    |=> (out_valid && out_byte == 8'hFF)); // R2
  AST_LED_SWALLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && led_pend && !key_valid && count == '0) |=> !out_valid); // R4
  AST_UNKNOWN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !led_pend && cmd_byte != CMD_RST && cmd_byte != CMD_LAYOUT &&
     cmd_byte != CMD_LED && !key_valid && count == '0) |=> !out_valid); // R5
  AST_PREFIX_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (key_valid && key_ext && !cmd_valid && count == '0) |=> !out_valid); // R7
endmodule

// File: tb/kbd_cmd_filter_test.sv
module kbd_cmd_filter_test;
  logic clk = 0, rst_n = 0;
  logic cmd_valid = 0, key_valid = 0, key_ext = 0;
  logic [7:0] cmd_byte = 0, key_code = 0;
  logic out_valid;
  logic [7:0] out_byte;

  kbd_cmd_filter uut (.clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_byte(cmd_byte),
    .key_valid(key_valid), .key_code(key_code), .key_ext(key_ext),
    .out_valid(out_valid), .out_byte(out_byte));

  always #5 clk = ~clk;

  int checks = 0, errors = 0, cyc = 0, nrec = 0, strobe_cyc = 0;
  logic [7:0] rec [64];
  int rec_cyc [64];

  always @(posedge clk) cyc <= cyc + 1;
  always @(negedge clk) if (rst_n && out_valid && nrec < 64) begin
    rec[nrec] = out_byte; rec_cyc[nrec] = cyc; nrec = nrec + 1;
  end

  function automatic logic [7:0] tr(input logic [7:0] c, input bit ext);
    return {c[7], 7'((c[6:0] + (ext ? 7'd64 : 7'd17)) & 7'h7F)};
  endfunction

  task automatic chk_count(string tag, int exp);
    checks++;
    if (nrec != exp) begin errors++; $display("FAIL %s count actual %0d expected %0d", tag, nrec, exp); end
  endtask

  task automatic chk_byte(string tag, int idx, logic [7:0] exp);
    checks++;
    if (idx >= nrec || rec[idx] !== exp) begin
      errors++;
      $display("FAIL %s byte %0d actual %h expected %h", tag, idx, (idx < nrec) ? rec[idx] : 8'hxx, exp);
    end
  endtask

  task automatic send_cmd(logic [7:0] b);
    @(negedge clk); cmd_valid = 1; cmd_byte = b; strobe_cyc = cyc;
    @(negedge clk); cmd_valid = 0;
  endtask

  task automatic send_key(logic [7:0] c, logic e);
    @(negedge clk); key_valid = 1; key_code = c; key_ext = e;
    @(negedge clk); key_valid = 0; key_ext = 0;
  endtask

  task automatic settle(); repeat (14) @(negedge clk); endtask
  task automatic clear(); nrec = 0; endtask

  task automatic t_reset();
    repeat (4) @(negedge clk);
    checks++;
    if (out_valid !== 1'b0) begin errors++; $display("FAIL R1 out_valid actual %b expected 0", out_valid); end
    chk_count("R1", 0);
  endtask

  task automatic t_reset_cmd();
    clear(); send_cmd(8'h01); settle();
    chk_count("R2", 2); chk_byte("R2", 0, 8'hFF); chk_byte("R2", 1, 8'h04);
    checks++;
    if (nrec < 2 || rec_cyc[0] != strobe_cyc + 1 || rec_cyc[1] != rec_cyc[0] + 1) begin
      errors++; $display("FAIL R11 timing actual %0d,%0d expected %0d,%0d",
        rec_cyc[0], rec_cyc[1], strobe_cyc + 1, strobe_cyc + 2);
    end
  endtask

  task automatic t_layout();
    clear(); send_cmd(8'h07); settle();
    chk_count("R3", 2); chk_byte("R3", 0, 8'hFE); chk_byte("R3", 1, 8'h00);
  endtask

  task automatic t_led();
    clear(); send_cmd(8'h0E); send_cmd(8'h01); settle();
    chk_count("R4 swallow", 0);
    send_cmd(8'h07); settle();
    chk_count("R4 resume", 2); chk_byte("R4", 0, 8'hFE);
  endtask

  task automatic t_unknown();
    clear(); send_cmd(8'h00); send_cmd(8'h02); send_cmd(8'hFF); send_cmd(8'h0F); settle();
    chk_count("R5", 0);
  endtask

  task automatic t_translate();
    clear(); send_key(8'h05, 0); send_key(8'h85, 0); send_key(8'h7F, 0); settle();
    chk_count("R6", 3);
    chk_byte("R6", 0, tr(8'h05, 0)); chk_byte("R6", 1, tr(8'h85, 0)); chk_byte("R6", 2, tr(8'h7F, 0));
  endtask

  task automatic t_ext();
    clear(); send_key(8'hE0, 1); settle();
    chk_count("R7 prefix", 0);
    send_key(8'h7F, 0); send_key(8'h7F, 0); settle();
    chk_count("R7", 2); chk_byte("R7 ext", 0, tr(8'h7F, 1)); chk_byte("R7 cleared", 1, tr(8'h7F, 0));
  endtask

  task automatic t_locks();
    clear();
    send_key(8'd58, 0); send_key(8'd186, 0); send_key(8'd58, 0); send_key(8'd186, 0); settle();
    chk_count("R8 caps", 2); chk_byte("R8 caps", 0, tr(8'd58, 0)); chk_byte("R8 caps", 1, tr(8'd186, 0));
    clear(); send_key(8'hE0, 1); send_key(8'd69, 0); settle();
    chk_count("R8 num", 1); chk_byte("R8 num ext", 0, tr(8'd69, 1));
    clear(); send_key(8'hE0, 1); send_key(8'd197, 0); send_key(8'h10, 0); send_key(8'h10, 0); settle();
    chk_count("R8 drop", 2); chk_byte("R8 arm kept", 0, tr(8'h10, 1)); chk_byte("R8", 1, tr(8'h10, 0));
  endtask

  task automatic t_order();
    clear();
    @(negedge clk); cmd_valid = 1; cmd_byte = 8'h07; key_valid = 1; key_code = 8'h05;
    @(negedge clk); cmd_valid = 0; key_valid = 0;
    settle();
    chk_count("R9", 3); chk_byte("R9", 0, 8'hFE); chk_byte("R9", 1, 8'h00); chk_byte("R9", 2, tr(8'h05, 0));
  endtask

  task automatic t_overflow();
    logic [7:0] exp [13];
    clear();
    @(negedge clk); cmd_valid = 1; cmd_byte = 8'h01; key_valid = 1; key_code = 8'h05;
    repeat (6) @(negedge clk);
    cmd_valid = 0; key_valid = 0;
    settle();
    for (int i = 0; i < 3; i++) begin exp[3*i] = 8'hFF; exp[3*i+1] = 8'h04; exp[3*i+2] = tr(8'h05, 0); end
    exp[9] = 8'hFF; exp[10] = 8'h04; exp[11] = 8'hFF; exp[12] = 8'hFF;
    chk_count("R10", 13);
    for (int i = 0; i < 13; i++) chk_byte("R10", i, exp[i]);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset(); t_reset_cmd(); t_layout(); t_led(); t_unknown();
    t_translate(); t_ext(); t_locks(); t_order(); t_overflow();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule